// File: doc/BRIEF.md
# Modem Configuration Register Write Port

This block is a write-only serial slave that holds the configuration registers of a low-speed FSK modem. A host drives three wires: a serial clock that idles low, a data line, and a frame-enable line that stays high for the whole frame. All three are brought into the system clock domain through synchronizers. A frame opens when the enable line rises. Its first byte is the target address, and the data bytes follow it. Each bit is taken on a falling edge of the serial clock, most significant bit first, while the host changes data on rising edges.

Three 8-bit registers take two data bytes. The first is a guard byte that must equal the bitwise complement of the second, which holds the value. A 24-bit sigma-delta register takes three data bytes, and seventeen of those bits form the converter value. Nothing is written while the frame is running. When the enable line falls, a state machine judges the whole frame: the address, the number of bits received and the guard byte. It then either commits the value or discards it and pulses an error flag. Each accepted sigma-delta write also gives a one-cycle update strobe, which a watchdog kick-source selection can use downstream.

The frame machine has four states. ST_IDLE waits for a frame. ST_CMD collects the 8 address bits. ST_PAYLOAD collects up to 24 data bits. ST_OVERRUN is reached when more data bits arrive than any register accepts. The transitions are:
- A rising enable line moves any state to ST_CMD.
- The eighth serial-clock fall in ST_CMD moves it to ST_PAYLOAD.
- A 25th data bit moves ST_PAYLOAD to ST_OVERRUN.
- A falling enable line moves any state to ST_IDLE, and the frame is judged at that moment.

Top module: `modem_cfg_spi`

## Requirements
- R1: After reset the registers read general = 0x00, clock = 0xFF, analog = 0xFD, sigma-delta value = 0, and neither sd_strobe nor frame_err pulses.
- R2: Bits are taken on falling edges of spi_sclk while spi_cs is high, most significant bit first. The host changes spi_mosi only after a rising edge.
- R3: A frame of exactly 24 bits, address 0x01 (general), 0x02 (clock) or 0x03 (analog), with its first data byte equal to the bitwise complement of its second, writes the second byte into the addressed register.
- R4: An 8-bit register frame whose guard byte is not the complement of its value byte changes no register and gives one frame_err pulse.
- R5: A frame of exactly 32 bits to address 0x0A loads the sigma-delta value with data byte 1 as bits 16:9, data byte 2 as bits 8:1 and bit 7 of data byte 3 as bit 0. Bits 6:0 of byte 3 are ignored.
- R6: A frame whose bit count does not match its address changes no register and gives one frame_err pulse. This covers 32 bits to an 8-bit register, 24 bits to address 0x0A, and a frame holding only the address byte.
- R7: A frame to any other address changes no register and gives one frame_err pulse.
- R8: Serial clock edges and data while spi_cs is low have no effect on any register or on frame_err.
- R9: sd_strobe is exactly one system-clock pulse for each accepted sigma-delta frame, and there is none for 8-bit register writes or rejected frames.
- R10: An accepted write changes only the addressed register.
- R11: Registers change only after spi_cs falls, never while a frame is still open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | Serial clock, idle low, asynchronous |
| spi_mosi | input | 1 | Serial data, taken on falling edges of spi_sclk |
| spi_cs | input | 1 | Frame enable, high for the duration of a frame |
| gen_cfg | output | 8 | General register; bits 3:2 select kick source (00 off, 01 external pulse, 10 sigma-delta write, 11 off) |
| clk_cfg | output | 8 | Clock-divider register |
| ana_cfg | output | 8 | Analog-enable register; bit 0 enables the sigma-delta converter |
| sd_value | output | 17 | Sigma-delta converter value |
| sd_strobe | output | 1 | One-cycle pulse per accepted sigma-delta write |
| frame_err | output | 1 | One-cycle pulse per rejected frame |

## Verification
The hardest case to reach is the decision at the close of a frame whose every byte looks plausible but whose total bit count belongs to a different register: a well-formed 8-bit write with one byte too many, or a sigma-delta write one byte short. The stimulus table drives whole frames of a chosen bit length through the serial pins, so each bad length is a frame built on purpose. A directed test also holds spi_cs high after the final bit, to show that no register moves before the enable line falls.

// File: rtl/cfgspi_pkg.sv
package cfgspi_pkg;
    localparam int BYTE_W   = 8;
    localparam int SD_W     = 17;
    localparam int PAY_MAX  = 3 * BYTE_W;
    localparam int PAY_CW   = $clog2(PAY_MAX + 1);
    localparam int CMD_CW   = $clog2(BYTE_W);

    localparam logic [BYTE_W-1:0] ADDR_GEN = 8'h01;
    localparam logic [BYTE_W-1:0] ADDR_CLK = 8'h02;
    localparam logic [BYTE_W-1:0] ADDR_ANA = 8'h03;
    localparam logic [BYTE_W-1:0] ADDR_SD  = 8'h0A;

    localparam logic [BYTE_W-1:0] RST_GEN = 8'h00;
    localparam logic [BYTE_W-1:0] RST_CLK = 8'hFF;
    localparam logic [BYTE_W-1:0] RST_ANA = 8'hFD;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CMD,
        ST_PAYLOAD,
        ST_OVERRUN
    } frame_state_t;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_GEN,
        SEL_CLK,
        SEL_ANA,
        SEL_SD
    } reg_sel_t;
endpackage

// File: rtl/cfgspi_sync.sv
module cfgspi_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], async_in[g]};
        end
        assign sync_out[g] = chain[STAGES-1];
    end
endmodule

// File: rtl/cfgspi_frame.sv
module cfgspi_frame
    import cfgspi_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cs_lvl,
    input  logic                sclk_lvl,
    input  logic                data_lvl,
    output logic                commit_vld,
    output reg_sel_t            commit_sel,
    output logic [PAY_MAX-1:0]  commit_word,
    output logic                frame_err
);
    frame_state_t         state, nxt;
    logic                 cs_q, sclk_q;
    logic                 cs_rise, cs_fall, sclk_fall;
    logic [BYTE_W-1:0]    cmd_sh;
    logic [CMD_CW-1:0]    cmd_cnt;
    logic [PAY_MAX-1:0]   pay_sh;
    logic [PAY_CW-1:0]    pay_cnt;
    reg_sel_t             sel;
    logic                 ok8, oksd, good;

    assign cs_rise   =  cs_lvl & ~cs_q;
    assign cs_fall   = ~cs_lvl &  cs_q;
    assign sclk_fall = ~sclk_lvl & sclk_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    nxt = ST_IDLE;
            ST_CMD:     if (sclk_fall && cmd_cnt == CMD_CW'(BYTE_W - 1)) nxt = ST_PAYLOAD;
            ST_PAYLOAD: if (sclk_fall && pay_cnt == PAY_CW'(PAY_MAX))    nxt = ST_OVERRUN;
            ST_OVERRUN: nxt = ST_OVERRUN;
            default:    nxt = ST_IDLE;
        endcase
        if (cs_fall) nxt = ST_IDLE;
        if (cs_rise) nxt = ST_CMD;
    end

    // bit collection
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q    <= 1'b0;
            sclk_q  <= 1'b0;
            cmd_sh  <= '0;
            cmd_cnt <= '0;
            pay_sh  <= '0;
            pay_cnt <= '0;
        end else begin
            cs_q   <= cs_lvl;
            sclk_q <= sclk_lvl;
            if (cs_rise) begin
                cmd_sh  <= '0;
                cmd_cnt <= '0;
                pay_sh  <= '0;
                pay_cnt <= '0;
            end else if (sclk_fall && state == ST_CMD) begin
                cmd_sh  <= {cmd_sh[BYTE_W-2:0], data_lvl};
                cmd_cnt <= cmd_cnt + 1'b1;
            end else if (sclk_fall && state == ST_PAYLOAD && pay_cnt != PAY_CW'(PAY_MAX)) begin
                pay_sh  <= {pay_sh[PAY_MAX-2:0], data_lvl};
                pay_cnt <= pay_cnt + 1'b1;
            end
        end
    end

    always_comb begin
        unique case (cmd_sh)
            ADDR_GEN: sel = SEL_GEN;
            ADDR_CLK: sel = SEL_CLK;
            ADDR_ANA: sel = SEL_ANA;
            ADDR_SD:  sel = SEL_SD;
            default:  sel = SEL_NONE;
        endcase
    end

    assign ok8  = (sel == SEL_GEN || sel == SEL_CLK || sel == SEL_ANA)
                  && pay_cnt == PAY_CW'(2 * BYTE_W)
                  && pay_sh[2*BYTE_W-1:BYTE_W] == ~pay_sh[BYTE_W-1:0];
    assign oksd = (sel == SEL_SD) && pay_cnt == PAY_CW'(PAY_MAX);
    assign good = (state == ST_PAYLOAD) && (ok8 || oksd);

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            commit_vld  <= 1'b0;
            commit_sel  <= SEL_NONE;
            commit_word <= '0;
            frame_err   <= 1'b0;
        end else begin
            commit_vld <= 1'b0;
            frame_err  <= 1'b0;
            if (cs_fall && state != ST_IDLE) begin
                if (good) begin
                    commit_vld  <= 1'b1;
                    commit_sel  <= sel;
                    commit_word <= pay_sh;
                end else begin
                    frame_err   <= 1'b1;
                end
            end
        end
    end

    // R11: a commit only follows the close of a frame
    assert_commit_on_close_R11: assert property (@(posedge clk) disable iff (!rst_n)
        commit_vld |-> $past(cs_q) && !$past(cs_lvl));
    // R6: an error only follows the close of a frame
    assert_err_on_close_R6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |-> $past(cs_q) && !$past(cs_lvl));
    // R8: a low frame-enable line keeps the machine idle
    assert_idle_when_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_lvl && !cs_q) |=> state == ST_IDLE);
endmodule

// File: rtl/cfgspi_regs.sv
module cfgspi_regs
    import cfgspi_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                commit_vld,
    input  reg_sel_t            commit_sel,
    input  logic [PAY_MAX-1:0]  commit_word,
    output logic [BYTE_W-1:0]   gen_cfg,
    output logic [BYTE_W-1:0]   clk_cfg,
    output logic [BYTE_W-1:0]   ana_cfg,
    output logic [SD_W-1:0]     sd_value,
    output logic                sd_strobe
);
    localparam int SD_LSB = PAY_MAX - SD_W;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gen_cfg   <= RST_GEN;
            clk_cfg   <= RST_CLK;
            ana_cfg   <= RST_ANA;
            sd_value  <= '0;
            sd_strobe <= 1'b0;
        end else begin
            sd_strobe <= 1'b0;
            if (commit_vld) begin
                unique case (commit_sel)
                    SEL_GEN: gen_cfg <= commit_word[BYTE_W-1:0];
                    SEL_CLK: clk_cfg <= commit_word[BYTE_W-1:0];
                    SEL_ANA: ana_cfg <= commit_word[BYTE_W-1:0];
                    SEL_SD: begin
                        sd_value  <= commit_word[PAY_MAX-1:SD_LSB];
                        sd_strobe <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    assert_strobe_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sd_strobe |=> !sd_strobe);
    assert_sd_moves_with_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_value != $past(sd_value)) |-> sd_strobe);
    assert_ana_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(commit_vld && commit_sel == SEL_ANA) |=> $stable(ana_cfg));
    assert_gen_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(commit_vld && commit_sel == SEL_GEN) |=> $stable(gen_cfg));
endmodule

// File: rtl/modem_cfg_spi.sv
module modem_cfg_spi
    import cfgspi_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               spi_sclk,
    input  logic               spi_mosi,
    input  logic               spi_cs,
    output logic [BYTE_W-1:0]  gen_cfg,
    output logic [BYTE_W-1:0]  clk_cfg,
    output logic [BYTE_W-1:0]  ana_cfg,
    output logic [SD_W-1:0]    sd_value,
    output logic               sd_strobe,
    output logic               frame_err
);
    logic [2:0]          pins_s;
    logic                commit_vld;
    reg_sel_t            commit_sel;
    logic [PAY_MAX-1:0]  commit_word;

    cfgspi_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({spi_cs, spi_sclk, spi_mosi}),
        .sync_out (pins_s)
    );

    cfgspi_frame u_frame (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_lvl      (pins_s[2]),
        .sclk_lvl    (pins_s[1]),
        .data_lvl    (pins_s[0]),
        .commit_vld  (commit_vld),
        .commit_sel  (commit_sel),
        .commit_word (commit_word),
        .frame_err   (frame_err)
    );

    cfgspi_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .commit_vld  (commit_vld),
        .commit_sel  (commit_sel),
        .commit_word (commit_word),
        .gen_cfg     (gen_cfg),
        .clk_cfg     (clk_cfg),
        .ana_cfg     (ana_cfg),
        .sd_value    (sd_value),
        .sd_strobe   (sd_strobe)
    );
endmodule

// File: tb/modem_cfg_spi_tb.sv
module modem_cfg_spi_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic spi_sclk = 1'b0, spi_mosi = 1'b0, spi_cs = 1'b0;
    logic [7:0]  gen_cfg, clk_cfg, ana_cfg;
    logic [16:0] sd_value;
    logic        sd_strobe, frame_err;

    int checks = 0, errors = 0;
    int n_err_p = 0, n_stb_p = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    modem_cfg_spi u_dut (
        .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
        .spi_cs(spi_cs), .gen_cfg(gen_cfg), .clk_cfg(clk_cfg), .ana_cfg(ana_cfg),
        .sd_value(sd_value), .sd_strobe(sd_strobe), .frame_err(frame_err)
    );

    always @(negedge clk) begin
        if (frame_err) n_err_p++;
        if (sd_strobe) n_stb_p++;
    end

    typedef struct packed {
        logic [5:0]  nbits;
        logic [31:0] bits;
        logic [7:0]  gen;
        logic [7:0]  clkv;
        logic [7:0]  ana;
        logic [16:0] sd;
        logic        err;
        logic        stb;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{6'd24, 32'h01F20D00, 8'h0D, 8'hFF, 8'hFD, 17'h00000, 1'b0, 1'b0}, // R3 R2 general
        '{6'd24, 32'h02A55A00, 8'h0D, 8'h5A, 8'hFD, 17'h00000, 1'b0, 1'b0}, // R3 R10 clock
        '{6'd24, 32'h03C33C00, 8'h0D, 8'h5A, 8'h3C, 17'h00000, 1'b0, 1'b0}, // R3 analog
        '{6'd24, 32'h01007700, 8'h0D, 8'h5A, 8'h3C, 17'h00000, 1'b1, 1'b0}, // R4 bad guard
        '{6'd32, 32'h0AABCDFF, 8'h0D, 8'h5A, 8'h3C, 17'h1579B, 1'b0, 1'b1}, // R5 R9 sigma-delta
        '{6'd32, 32'h0A123400, 8'h0D, 8'h5A, 8'h3C, 17'h02468, 1'b0, 1'b1}, // R5 second value
        '{6'd24, 32'h05FA0500, 8'h0D, 8'h5A, 8'h3C, 17'h02468, 1'b1, 1'b0}, // R7 unknown address
        '{6'd32, 32'h01EE1100, 8'h0D, 8'h5A, 8'h3C, 17'h02468, 1'b1, 1'b0}, // R6 too long
        '{6'd24, 32'h0AFFFF00, 8'h0D, 8'h5A, 8'h3C, 17'h02468, 1'b1, 1'b0}, // R6 sd too short
        '{6'd8,  32'h01000000, 8'h0D, 8'h5A, 8'h3C, 17'h02468, 1'b1, 1'b0}, // R6 address only
        '{6'd24, 32'h03FF0000, 8'h0D, 8'h5A, 8'h00, 17'h02468, 1'b0, 1'b0}  // R3 R10 value zero
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic shift_bits(input int nbits, input logic [31:0] bits);
        for (int i = 0; i < nbits; i++) begin
            spi_sclk = 1'b1;
            spi_mosi = bits[31 - i];
            wait_clk(4);
            spi_sclk = 1'b0;
            wait_clk(4);
        end
    endtask

    task automatic open_frame(input int nbits, input logic [31:0] bits);
        spi_cs = 1'b1;
        wait_clk(4);
        shift_bits(nbits, bits);
        wait_clk(4);
    endtask

    task automatic close_frame();
        spi_cs = 1'b0;
        wait_clk(12);
    endtask

    initial begin
        int e0, s0;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(3);
        // R1 reset values
        chk(gen_cfg == 8'h00, "R1 general", gen_cfg, 8'h00);
        chk(clk_cfg == 8'hFF, "R1 clock", clk_cfg, 8'hFF);
        chk(ana_cfg == 8'hFD, "R1 analog", ana_cfg, 8'hFD);
        chk(sd_value == 17'h0, "R1 sd", sd_value, 0);
        chk(n_err_p == 0 && n_stb_p == 0, "R1 pulses", n_err_p + n_stb_p, 0);

        for (int v = 0; v < NV; v++) begin
            e0 = n_err_p;
            s0 = n_stb_p;
            open_frame(int'(VECS[v].nbits), VECS[v].bits);
            close_frame();
            chk(gen_cfg == VECS[v].gen, $sformatf("R10 vec%0d general", v), gen_cfg, VECS[v].gen);
            chk(clk_cfg == VECS[v].clkv, $sformatf("R3 vec%0d clock", v), clk_cfg, VECS[v].clkv);
            chk(ana_cfg == VECS[v].ana, $sformatf("R3 vec%0d analog", v), ana_cfg, VECS[v].ana);
            chk(sd_value == VECS[v].sd, $sformatf("R5 vec%0d sd", v), sd_value, VECS[v].sd);
            chk(n_err_p - e0 == int'(VECS[v].err), $sformatf("R6 vec%0d err pulses", v),
                n_err_p - e0, VECS[v].err);
            chk(n_stb_p - s0 == int'(VECS[v].stb), $sformatf("R9 vec%0d strobe pulses", v),
                n_stb_p - s0, VECS[v].stb);
        end

        // R11: value held back until the frame closes
        open_frame(24, 32'h01CC3300);
        chk(gen_cfg == 8'h0D, "R11 before close", gen_cfg, 8'h0D);
        close_frame();
        chk(gen_cfg == 8'h33, "R11 after close", gen_cfg, 8'h33);

        // R8: clocking with enable low is ignored
        e0 = n_err_p;
        shift_bits(24, 32'h01F20D00);
        wait_clk(12);
        chk(gen_cfg == 8'h33, "R8 general untouched", gen_cfg, 8'h33);
        chk(n_err_p == e0, "R8 no error pulse", n_err_p - e0, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog R1-wide timeout actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule